// File: doc/BRIEF.md
# I2S Master Audio Serial Controller

This block is a timing-master stereo audio serial port. It runs from one master clock at 256 times the sample rate. It divides that clock by four to make the bit clock, which gives 64 bit slots per frame and 32 slots per channel. It also drives the word-select line. Samples written into a transmit FIFO go out on the serial data pin, left channel first. Serial data coming back in is gathered into words and placed in a receive FIFO.

Software sets up the port through a configuration register. This register selects the frame format (standard I2S with a one-bit delay, left-justified or right-justified), the word length, the polarity of the bit clock and of word select, internal loopback, and whether the data pin is an input. A separate enable register has a stop bit and a clock-run bit. Writing both bits and then the clock-run bit alone gives a clean restart. The configuration register also holds sticky error flags, which are cleared by writing one to them, and live FIFO level bits.

Top module: `i2s_master_ctrl`

## Requirements
- R1: After reset the enable register reads 2 (stop bit 1 set, clock-run bit 0 clear). The configuration register reads 0x0030_0000 (only the transmit-not-full bit 21 and transmit-empty bit 20 are set). `sck` is low, `ws` is high and `sd_oe` is high.
- R2: While running, `sck` has a period of 4 clocks: low for 2 clocks, then high for 2. Each slot starts on a falling edge. `sd_out` changes only at the start of a slot. `ws` (before inversion) is low for the 32 slots of the left half-frame and high for the 32 slots of the right half-frame. The first slot begins on the clock edge after the enable write that starts the block.
- R3: Configuration bits 8:7 select the format. With 0 (I2S) the sample MSB is in slot 1 of each half. With 1 (left-justified) the MSB is in slot 0. With 2 (right-justified) the LSB is in slot 31. Value 3 behaves as 1. Every slot outside the sample is sent as 0.
- R4: Configuration bits 4:0 give the word length N (8, 16, 18, 20 or 24). Samples are right-aligned in the 24-bit FIFO word, and only the low N bits are sent. Values above 24 act as 24.
- R5: Configuration bit 12 inverts `sck` and bit 9 inverts `ws`.
- R6: Configuration bit 10 routes the transmitted serial data into the receiver. Bit 11 drives `sd_oe` low and makes the receiver take `sd_in`.
- R7: Configuration bit 6 enables transmit FIFO use. The first FIFO entry after a restart goes to the left half. When bit 6 is clear, zeros are sent and nothing is popped. When bit 5 is clear, the receiver pushes nothing into the receive FIFO.
- R8: If the transmit FIFO is empty at the start of a half-frame while bit 6 is set, that half is sent as zeros and sticky bit 25 is set.
- R9: Sticky bits are: 24 (push into a full transmit FIFO), 23 (pop from an empty receive FIFO) and 22 (receive push while the receive FIFO is full). Writing 1 to any of bits 25..22 clears that bit. A set event in the same cycle as the clear wins. Read-only bits: 21 transmit not full, 20 transmit empty, 19 transmit full, 18 receive not empty, 17 receive full.
- R10: Enable register bit 1 (stop) holds the frame timing before slot 0. Any write with bit 1 set empties both FIFOs. The block runs only when bit 0 is 1 and bit 1 is 0. Otherwise `sck` stays at its idle level.
- R11: At the rising bit-clock edge of slot 31 of every half, the received N-bit word is pushed right-aligned into the receive FIFO when bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 configuration, 1 enable |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 configuration, 1 enable |
| reg_rd_data | output | 32 | Read data (combinational) |
| tx_push | input | 1 | Push a transmit sample |
| tx_data | input | 24 | Transmit sample, right-aligned |
| rx_pop | input | 1 | Pop the receive FIFO head |
| rx_data | output | 24 | Receive FIFO head, right-aligned |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial data pin output enable |
| sd_in | input | 1 | Serial data in |

## Verification
A transmit underflow can set sticky bit 25 on the very edge where software writes 1 to clear that bit. The bench provokes this by starting the block with an empty transmit FIFO. It issues the clearing write on the first slot edge, which is also where the first half-frame load underflows. The flag must read back as set. A clear issued in the middle of the half must then read back as cleared. Serial words in every format and length are judged slot by slot against a bench model of the frame layout, and again after they return through loopback.

// File: rtl/i2s_pkg.sv
package i2s_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int HALF_SLOTS = 32;
  localparam int SLOT_W     = $clog2(HALF_SLOTS);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       sck_inv;
    logic       pin_in;
    logic       loop_en;
    logic       ws_inv;
    fmt_e       fmt;
    logic       tx_en;
    logic       rx_en;
    logic [4:0] size;
  } cfg_t;

  typedef struct packed {
    logic              valid;
    logic [SLOT_W-1:0] idx;
  } map_t;

  // Where a slot of a half-frame falls inside the sample, if at all.
  function automatic map_t slot_map(input logic [SLOT_W-1:0] slot,
                                    input fmt_e fmt,
                                    input logic [4:0] size);
    logic [SLOT_W:0] n;
    logic [SLOT_W:0] off;
    logic [SLOT_W:0] rel;
    map_t            m;
    n = (size > 5'(SAMPLE_W)) ? (SLOT_W+1)'(SAMPLE_W) : {1'b0, size};
    case (fmt)
      FMT_I2S: off = (SLOT_W+1)'(1);
      FMT_RJ:  off = (SLOT_W+1)'(HALF_SLOTS) - n;
      default: off = '0;
    endcase
    rel     = {1'b0, slot} - off;
    m.valid = ({1'b0, slot} >= off) && (rel < n);
    m.idx   = SLOT_W'(n - (SLOT_W+1)'(1) - rel);
    return m;
  endfunction
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [AW:0]      cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr_q] <= din;
  end
endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int DIV_W   = 2,
  parameter int FRAME_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               run,
  output logic [DIV_W-1:0]   div,
  output logic [FRAME_W-1:0] slot,
  output logic [FRAME_W-1:0] nslot,
  output logic               tick_edge,
  output logic               tick_mid
);
  localparam logic [DIV_W-1:0] DIV_LAST = '1;
  localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'((1 << DIV_W) / 2 - 1);

  logic [DIV_W-1:0]   div_q, div_d;
  logic [FRAME_W-1:0] slot_q, slot_d;

  assign div       = div_q;
  assign slot      = slot_q;
  assign nslot     = slot_q + 1'b1;
  assign tick_edge = run && !hold && (div_q == DIV_LAST);
  assign tick_mid  = run && !hold && (div_q == DIV_MID);

  always_comb begin
    div_d  = div_q;
    slot_d = slot_q;
    if (hold) begin
      div_d  = DIV_LAST;
      slot_d = '1;
    end else if (run) begin
      div_d = div_q + 1'b1;
      if (div_q == DIV_LAST) slot_d = nslot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_LAST;
      slot_q <= '1;
    end else begin
      div_q  <= div_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import i2s_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                tick_edge,
  input  logic [SLOT_W:0]     nslot,
  input  fmt_e                fmt,
  input  logic [4:0]          size,
  input  logic                tx_en,
  input  logic                fifo_empty,
  input  logic [SAMPLE_W-1:0] fifo_dout,
  output logic                fifo_pop,
  output logic                underrun,
  output logic                sd
);
  logic [SAMPLE_W-1:0] sample_q, sample_d;
  logic                sd_q, sd_d;
  logic                load;
  map_t                m;

  assign load     = tick_edge && (nslot[SLOT_W-1:0] == '0);
  assign fifo_pop = load && tx_en && !fifo_empty;
  assign underrun = load && tx_en && fifo_empty;
  assign sd       = sd_q;

  always_comb begin
    m        = slot_map(nslot[SLOT_W-1:0], fmt, size);
    sample_d = sample_q;
    if (load) sample_d = fifo_pop ? fifo_dout : '0;
    sd_d = sd_q;
    if (tick_edge) sd_d = m.valid ? sample_d[m.idx] : 1'b0;
    if (clear) begin
      sample_d = '0;
      sd_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      sample_q <= sample_d;
      sd_q     <= sd_d;
    end
  end
endmodule

// File: rtl/rx_deserializer.sv
module rx_deserializer
  import i2s_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                tick_mid,
  input  logic [SLOT_W-1:0]   slot,
  input  fmt_e                fmt,
  input  logic [4:0]          size,
  input  logic                rx_en,
  input  logic                bit_in,
  output logic                push,
  output logic [SAMPLE_W-1:0] word
);
  logic [SAMPLE_W-1:0] acc_q, acc_d, acc_n;
  logic                last;
  map_t                m;

  assign last = (slot == '1);
  assign push = tick_mid && last && rx_en && !clear;
  assign word = acc_n;

  always_comb begin
    m     = slot_map(slot, fmt, size);
    acc_n = m.valid ? {acc_q[SAMPLE_W-2:0], bit_in} : acc_q;
    acc_d = acc_q;
    if (tick_mid) acc_d = last ? '0 : acc_n;
    if (clear) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/i2s_master_ctrl.sv
module i2s_master_ctrl
  import i2s_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic                reg_wr_sel,
  input  logic [31:0]         reg_wr_data,
  input  logic                reg_rd_sel,
  output logic [31:0]         reg_rd_data,
  input  logic                tx_push,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                rx_pop,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                sck,
  output logic                ws,
  output logic                sd_out,
  output logic                sd_oe,
  input  logic                sd_in
);
  localparam int FRAME_W = SLOT_W + 1;

  cfg_t  cfg_q, cfg_d;
  logic  en_ce_q, en_ce_d, en_dis_q, en_dis_d;
  logic  flag_txu, flag_txo, flag_rxu, flag_rxo;
  logic  flag_txu_d, flag_txo_d, flag_rxu_d, flag_rxo_d;
  logic  cfg_wr, en_wr, flush, running;
  logic  [3:0] w1c;

  logic  [1:0]         tmr_div;
  logic  [FRAME_W-1:0] tmr_slot, tmr_nslot;
  logic                tick_edge, tick_mid;

  logic                tx_pop, tx_empty, tx_full, tx_underrun_evt, tx_sd;
  logic [SAMPLE_W-1:0] tx_head;
  logic                rx_push_int, rx_empty, rx_full, rx_bit;
  logic [SAMPLE_W-1:0] rx_word;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{reg_wr_data[31:26], reg_wr_data[21:13]};

  assign cfg_wr  = reg_wr_en && !reg_wr_sel;
  assign en_wr   = reg_wr_en && reg_wr_sel;
  assign flush   = en_wr && reg_wr_data[1];
  assign running = en_ce_q && !en_dis_q;
  assign w1c     = cfg_wr ? reg_wr_data[25:22] : 4'b0;

  // register bank next state
  always_comb begin
    cfg_d    = cfg_q;
    en_ce_d  = en_ce_q;
    en_dis_d = en_dis_q;
    if (cfg_wr) begin
      cfg_d.sck_inv = reg_wr_data[12];
      cfg_d.pin_in  = reg_wr_data[11];
      cfg_d.loop_en = reg_wr_data[10];
      cfg_d.ws_inv  = reg_wr_data[9];
      cfg_d.fmt     = fmt_e'(reg_wr_data[8:7]);
      cfg_d.tx_en   = reg_wr_data[6];
      cfg_d.rx_en   = reg_wr_data[5];
      cfg_d.size    = reg_wr_data[4:0];
    end
    if (en_wr) begin
      en_ce_d  = reg_wr_data[0];
      en_dis_d = reg_wr_data[1];
    end
    flag_txu_d = (flag_txu && !w1c[3]) || tx_underrun_evt;
    flag_txo_d = (flag_txo && !w1c[2]) || (tx_push && tx_full);
    flag_rxu_d = (flag_rxu && !w1c[1]) || (rx_pop && rx_empty);
    flag_rxo_d = (flag_rxo && !w1c[0]) || (rx_push_int && rx_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      en_ce_q  <= 1'b0;
      en_dis_q <= 1'b1;
      flag_txu <= 1'b0;
      flag_txo <= 1'b0;
      flag_rxu <= 1'b0;
      flag_rxo <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      en_ce_q  <= en_ce_d;
      en_dis_q <= en_dis_d;
      flag_txu <= flag_txu_d;
      flag_txo <= flag_txo_d;
      flag_rxu <= flag_rxu_d;
      flag_rxo <= flag_rxo_d;
    end
  end

  always_comb begin
    if (reg_rd_sel) begin
      reg_rd_data = {30'b0, en_dis_q, en_ce_q};
    end else begin
      reg_rd_data = {6'b0,
                     flag_txu, flag_txo, flag_rxu, flag_rxo,
                     !tx_full, tx_empty, tx_full, !rx_empty, rx_full,
                     4'b0,
                     cfg_q.sck_inv, cfg_q.pin_in, cfg_q.loop_en, cfg_q.ws_inv,
                     cfg_q.fmt, cfg_q.tx_en, cfg_q.rx_en, cfg_q.size};
    end
  end

  frame_timer #(.DIV_W(2), .FRAME_W(FRAME_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (en_dis_q),
    .run       (running),
    .div       (tmr_div),
    .slot      (tmr_slot),
    .nslot     (tmr_nslot),
    .tick_edge (tick_edge),
    .tick_mid  (tick_mid)
  );

  sample_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (tx_push),
    .din   (tx_data),
    .pop   (tx_pop),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  tx_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (en_dis_q),
    .tick_edge  (tick_edge),
    .nslot      (tmr_nslot),
    .fmt        (cfg_q.fmt),
    .size       (cfg_q.size),
    .tx_en      (cfg_q.tx_en),
    .fifo_empty (tx_empty),
    .fifo_dout  (tx_head),
    .fifo_pop   (tx_pop),
    .underrun   (tx_underrun_evt),
    .sd         (tx_sd)
  );

  assign rx_bit = cfg_q.loop_en ? tx_sd : sd_in;

  rx_deserializer u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (en_dis_q),
    .tick_mid (tick_mid),
    .slot     (tmr_slot[SLOT_W-1:0]),
    .fmt      (cfg_q.fmt),
    .size     (cfg_q.size),
    .rx_en    (cfg_q.rx_en),
    .bit_in   (rx_bit),
    .push     (rx_push_int),
    .word     (rx_word)
  );

  sample_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (rx_push_int),
    .din   (rx_word),
    .pop   (rx_pop),
    .dout  (rx_data),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign sck    = (running && tmr_div[1]) ^ cfg_q.sck_inv;
  assign ws     = tmr_slot[SLOT_W] ^ cfg_q.ws_inv;
  assign sd_out = tx_sd;
  assign sd_oe  = !cfg_q.pin_in;
endmodule

// File: rtl/i2s_master_ctrl_chk.sv
module i2s_master_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        running,
  input logic [1:0]  tmr_div,
  input logic        sck,
  input logic        ws,
  input logic        sd_out,
  input logic        sck_inv,
  input logic        ws_inv,
  input logic        tx_push,
  input logic        tx_full,
  input logic        tx_pop,
  input logic        tx_empty,
  input logic        tx_underrun_evt,
  input logic        rx_push_int,
  input logic        rx_full,
  input logic        flag_txu,
  input logic        flag_txo,
  input logic        flag_rxo,
  input logic        reg_wr_en,
  input logic        reg_wr_sel,
  input logic [31:0] reg_wr_data
);
  // R2: data only moves at a slot boundary
  p_sd_slot_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && tmr_div != 2'd0 |-> $stable(sd_out));

  // R2: rising bit clock in the middle of a slot
  p_sck_mid_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && tmr_div == 2'd2 && $stable(sck_inv) |-> !$stable(sck));

  // R2: word select only moves at slot boundaries
  p_ws_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && tmr_div != 2'd0 && $stable(ws_inv) |-> $stable(ws));

  // R10: bit clock frozen while not running
  p_sck_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running && $past(!running) && $stable(sck_inv) |-> $stable(sck));

  // R8: the serializer never pops an empty FIFO
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R9: a set event wins over a same-cycle clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun_evt |=> flag_txu);

  // R9: sticky until cleared
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_txu && !(reg_wr_en && !reg_wr_sel && reg_wr_data[25]) |=> flag_txu);

  // R9: push into full transmit FIFO is flagged
  p_txo_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && tx_full |=> flag_txo);

  // R11: receive push into full FIFO is flagged
  p_rxo_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_int && rx_full |=> flag_rxo);
endmodule

bind i2s_master_ctrl i2s_master_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .running         (running),
  .tmr_div         (tmr_div),
  .sck             (sck),
  .ws              (ws),
  .sd_out          (sd_out),
  .sck_inv         (cfg_q.sck_inv),
  .ws_inv          (cfg_q.ws_inv),
  .tx_push         (tx_push),
  .tx_full         (tx_full),
  .tx_pop          (tx_pop),
  .tx_empty        (tx_empty),
  .tx_underrun_evt (tx_underrun_evt),
  .rx_push_int     (rx_push_int),
  .rx_full         (rx_full),
  .flag_txu        (flag_txu),
  .flag_txo        (flag_txo),
  .flag_rxo        (flag_rxo),
  .reg_wr_en       (reg_wr_en),
  .reg_wr_sel      (reg_wr_sel),
  .reg_wr_data     (reg_wr_data)
);

// File: tb/tb_i2s_master_ctrl.sv
module tb_i2s_master_ctrl;
  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic        reg_wr_en, reg_wr_sel, reg_rd_sel;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        tx_push, rx_pop;
  logic [23:0] tx_data, rx_data;
  logic        sck, ws, sd_out, sd_oe, sd_in;

  int n_tests = 0;
  int n_fail  = 0;

  i2s_master_ctrl #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .tx_push(tx_push), .tx_data(tx_data),
    .rx_pop(rx_pop), .rx_data(rx_data),
    .sck(sck), .ws(ws), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected finish", 150000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int eff_n(input int size);
    return (size > 24) ? 24 : size;
  endfunction

  function automatic logic [31:0] low_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // expected half-frame as 32 bits, slot 0 in bit 31
  function automatic logic [31:0] exp_half(input logic [23:0] s, input int fmt, input int size);
    int n = eff_n(size);
    logic [31:0] w = {8'b0, s} & low_mask(n);
    case (fmt)
      0:       return w << (31 - n);
      2:       return w;
      default: return w << (32 - n);
    endcase
  endfunction

  function automatic logic [31:0] cfg_word(input int fmt, input int size, input bit ick,
                                           input bit iws, input bit lb, input bit pin,
                                           input bit txe, input bit rxe);
    return (32'hF << 22) | (32'(ick) << 12) | (32'(pin) << 11) | (32'(lb) << 10) |
           (32'(iws) << 9) | (32'(fmt & 3) << 7) | (32'(txe) << 6) | (32'(rxe) << 5) |
           32'(size & 31);
  endfunction

  task automatic reg_wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(posedge clk);
    #1 reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input bit sel, output logic [31:0] v);
    @(negedge clk);
    reg_rd_sel = sel;
    #1 v = reg_rd_data;
  endtask

  task automatic push(input logic [23:0] d);
    @(negedge clk);
    tx_push = 1'b1; tx_data = d;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop(output logic [23:0] d);
    @(negedge clk);
    d = rx_data; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic run_stream(input int fmt, input int size, input bit ick, input bit iws,
                            input int nh, input int npush, input string tag);
    logic [23:0] samp [8];
    logic [31:0] obs, st;
    logic [23:0] got;
    bit          tim_ok;
    reg_wr(1'b1, 32'd3);
    reg_wr(1'b0, cfg_word(fmt, size, ick, iws, 1'b1, 1'b0, 1'b1, 1'b1));
    for (int i = 0; i < 8; i++) samp[i] = '0;
    for (int i = 0; i < npush; i++) begin
      samp[i] = 24'($urandom);
      push(samp[i]);
    end
    reg_rd_sel = 1'b0;
    st = '0;
    reg_wr(1'b1, 32'd1);
    @(posedge clk);
    for (int h = 0; h < nh; h++) begin
      obs = '0; tim_ok = 1'b1;
      for (int s = 0; s < 32; s++) begin
        @(negedge clk);
        obs[31-s] = sd_out;
        if (ws !== (1'(h) ^ iws)) tim_ok = 1'b0;
        if (sck !== ick) tim_ok = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (sck !== !ick) tim_ok = 1'b0;
        @(negedge clk);
        if (h == nh - 1 && s == 31) st = reg_rd_data;
      end
      check(obs == exp_half(samp[h], fmt, size), tag, "R3/R4 serial half-frame", obs,
            exp_half(samp[h], fmt, size));
      check(tim_ok, "R2", {tag, " sck/ws timing"}, 32'(tim_ok), 32'd1);
    end
    check(st[25] == (npush < nh), "R8", {tag, " underflow flag"}, 32'(st[25]), 32'(npush < nh));
    for (int h = 0; h < nh; h++) begin
      pop(got);
      check(got == (samp[h] & 24'(low_mask(eff_n(size)))), "R11", {tag, " R6 loopback word"},
            32'(got), 32'(samp[h] & 24'(low_mask(eff_n(size)))));
    end
    reg_wr(1'b1, 32'd2);
  endtask

  initial begin
    logic [31:0] v;
    logic [23:0] d;
    bit          same;
    int          sizes [5] = '{8, 16, 18, 20, 24};
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = 1'b0; reg_wr_data = '0;
    reg_rd_sel = 1'b0; tx_push = 1'b0; tx_data = '0; rx_pop = 1'b0; sd_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    reg_rd(1'b0, v); check(v == 32'h0030_0000, "R1", "config after reset", v, 32'h0030_0000);
    reg_rd(1'b1, v); check(v == 32'd2, "R1", "enable after reset", v, 32'd2);
    check({sck, ws, sd_oe} == 3'b011, "R1", "idle pins", 32'({sck, ws, sd_oe}), 32'b011);

    // directed formats and sizes
    run_stream(0, 16, 1'b0, 1'b0, 4, 4, "R3 i2s-16");
    run_stream(1, 24, 1'b1, 1'b1, 4, 4, "R5 lj-24-inverted");
    run_stream(2, 18, 1'b0, 1'b0, 4, 4, "R3 rj-18");
    run_stream(2, 20, 1'b0, 1'b1, 3, 3, "R4 rj-20");
    run_stream(0, 8, 1'b1, 1'b0, 2, 2, "R4 i2s-8");
    run_stream(3, 31, 1'b0, 1'b0, 2, 2, "R4 fmt3-size31");
    run_stream(1, 16, 1'b0, 1'b0, 4, 2, "R8 underflow");

    // R9 clear by writing one
    reg_wr(1'b0, cfg_word(0, 16, 0, 0, 0, 0, 0, 0));
    reg_rd(1'b0, v); check(v[25:22] == 4'b0, "R9", "w1c clears flags", 32'(v[25:22]), 32'd0);

    // random streams
    for (int i = 0; i < 6; i++) begin
      int nh = 2 + int'($urandom % 5);
      run_stream(int'($urandom % 4), sizes[$urandom % 5], 1'($urandom), 1'($urandom),
                 nh, nh, "R3 random");
    end

    // R9 transmit overflow, R10 flush
    reg_wr(1'b1, 32'd3);
    reg_wr(1'b0, cfg_word(0, 16, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < DEPTH + 1; i++) push(24'(i));
    reg_rd(1'b0, v);
    check(v[24] && v[19] && !v[21], "R9", "tx overflow and full", v & 32'h0128_0000, 32'h0108_0000);
    reg_wr(1'b1, 32'd3);
    reg_rd(1'b0, v); check(v[20] == 1'b1, "R10", "disable write empties tx", 32'(v[20]), 32'd1);

    // R9 receive underflow
    pop(d);
    reg_rd(1'b0, v); check(v[23] == 1'b1, "R9", "rx underflow flag", 32'(v[23]), 32'd1);

    // R11 receive overflow, R7 no underflow with tx disabled
    reg_wr(1'b0, cfg_word(1, 16, 0, 0, 1, 0, 0, 1));
    reg_wr(1'b1, 32'd1);
    repeat (128 * 10) @(posedge clk);
    reg_rd(1'b0, v);
    check(v[22] && v[17], "R11", "rx overflow and full", v & 32'h0042_0000, 32'h0042_0000);
    check(v[25] == 1'b0, "R7", "tx disabled sets no underflow", 32'(v[25]), 32'd0);
    reg_wr(1'b1, 32'd3);

    // R7 receive disabled pushes nothing, tx still consumed
    reg_wr(1'b0, cfg_word(1, 16, 0, 0, 1, 0, 1, 0));
    push(24'h00A5A5); push(24'h005A5A);
    reg_wr(1'b1, 32'd1);
    repeat (128 * 2 + 8) @(posedge clk);
    reg_rd(1'b0, v);
    check(v[18] == 1'b0, "R7", "rx disabled FIFO empty", 32'(v[18]), 32'd0);
    check(v[20] == 1'b1, "R7", "tx FIFO drained", 32'(v[20]), 32'd1);
    reg_wr(1'b1, 32'd3);

    // R6 data pin as input
    reg_wr(1'b0, cfg_word(0, 20, 0, 0, 0, 1, 0, 1));
    sd_in = 1'b1;
    @(negedge clk); check(sd_oe == 1'b0, "R6", "pin input disables driver", 32'(sd_oe), 32'd0);
    reg_wr(1'b1, 32'd1);
    repeat (128 + 8) @(posedge clk);
    pop(d); check(d == 24'h0F_FFFF, "R6", "rx from sd_in", 32'(d), 32'h000F_FFFF);
    reg_wr(1'b1, 32'd3);
    sd_in = 1'b0;

    // R9 set wins over same-cycle clear
    reg_wr(1'b0, cfg_word(0, 16, 0, 0, 0, 0, 1, 0));
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wr_data = 32'd1;
    @(posedge clk);
    #1 reg_wr_sel = 1'b0; reg_wr_data = cfg_word(0, 16, 0, 0, 0, 0, 1, 0);
    @(posedge clk);
    #1 reg_wr_en = 1'b0;
    reg_rd(1'b0, v); check(v[25] == 1'b1, "R9", "set wins over clear", 32'(v[25]), 32'd1);
    repeat (10) @(posedge clk);
    reg_wr(1'b0, cfg_word(0, 16, 0, 0, 0, 0, 1, 0));
    reg_rd(1'b0, v); check(v[25] == 1'b0, "R9", "mid-half clear", 32'(v[25]), 32'd0);

    // R10 stop and clock gate
    reg_wr(1'b1, 32'd2);
    reg_wr(1'b0, cfg_word(0, 16, 0, 0, 0, 0, 0, 0));
    same = 1'b1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck !== 1'b0) same = 1'b0; end
    check(same, "R10", "sck idle when stopped", 32'(same), 32'd1);
    reg_wr(1'b1, 32'd0);
    same = 1'b1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck !== 1'b0) same = 1'b0; end
    check(same, "R10", "sck idle when clock-run clear", 32'(same), 32'd1);
    reg_rd(1'b1, v); check(v == 32'd0, "R10", "enable readback", v, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule